// File: doc/BRIEF.md
# Compression Engine Command and Status Controller

This block is the host-facing control unit of a lossless compression and decompression engine. The host reaches it through a small synchronous register port with an 8-bit data path. Before it starts a job, the host loads a transfer size and a threshold setting for the compressed-side FIFO. It then writes a start opcode to the command register. The controller launches the job in one step. It pulses start and history-clear strobes to the datapath, resets both byte counters and the error-status register, and marks itself busy.

While the job runs, the datapath reports each original-side byte and each compressed-side byte with single-cycle ticks, and the controller counts them. The job ends in one of two ways. It completes when the original-byte count reaches the transfer size. It fails when the datapath raises an error, in which case the controller sends a one-cycle cancel pulse. Either way the controller pulls its active-low interrupt low and records the outcome in the status register. The interrupt stays low until the next job launches or a reset occurs.

The datapath itself is not part of this block. It is represented only by its start, clear, cancel, tick and error signals.

Top module: `zeng_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 except the threshold register, which reads THRESH_RST. irq_n is high, and fifo_thresh equals THRESH_RST.
- R2: A job launches when the host writes a start opcode to address 3 while idle and with a nonzero transfer size. The start opcodes are 0x01 for compress and 0x02 for decompress. In the cycle after the write, status (address 4) reads 0x80, error status (address 5) reads 0x00, and both counters read 0. Also in that cycle, irq_n is high, dp_start and dp_clear are high for exactly one cycle, and dp_mode is 0 for compress or 1 for decompress.
- R3: A start opcode written while the transfer size is zero does not launch. It sets error-status bit 1 and leaves status unchanged.
- R4: A start opcode written while busy is ignored. It sets error-status bit 0, and the job, its counters and dp_mode carry on unchanged.
- R5: While busy, dp_orig_tick increments the original counter (addresses 6 low and 7 high) and dp_comp_tick increments the compressed counter (addresses 8 low and 9 high). Ticks while idle change neither counter.
- R6: The original tick that brings the original count equal to the transfer size ends the job. From the next cycle, status reads 0x01 (bit 0 done, bit 7 busy clear) and irq_n is low.
- R7: dp_err while busy ends the job. It ORs dp_err_code into error-status bits 7:4, sets status to 0x02 and drives irq_n low, and dp_cancel pulses for one cycle. An error in the same cycle as the final original tick wins over completion, and that tick is still counted.
- R8: Once low, irq_n stays low until the next accepted launch, which drives it high, or until reset.
- R9: The transfer size is written through address 0 (low byte) and address 1 (high byte). Bits at or above CNT_W read as zero. Size writes while busy are ignored.
- R10: The threshold register at address 2 is writable at any time and drives fifo_thresh.
- R11: Writes of any value other than a start opcode to address 3 are ignored. Address 3 reads back the last accepted opcode.
- R12: Writes to the status, error-status and counter addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one write per cycle |
| host_rdata | output | 8 | Read data for host_addr |
| fifo_thresh | output | 8 | Compressed-side FIFO threshold |
| dp_mode | output | 1 | 0 compress, 1 decompress |
| dp_start | output | 1 | One-cycle job start strobe |
| dp_clear | output | 1 | One-cycle history clear strobe |
| dp_cancel | output | 1 | One-cycle cancel strobe on error |
| dp_orig_tick | input | 1 | One original-side byte moved |
| dp_comp_tick | input | 1 | One compressed-side byte moved |
| dp_err | input | 1 | Datapath error |
| dp_err_code | input | 4 | Error kind bits, valid with dp_err |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with CNT_W = 12 and THRESH_RST = 0x2A. The narrow counter width brings the masking of unused high size bits within reach: writing 0xFF to the high byte must read back as 0x0F. The non-zero threshold reset value makes a missed reset of that register visible. A transfer size of 300 carries both counters across the byte boundary, so the high-byte readback is checked with a real carry. The same run lets an error land on the final original tick, which exercises the rule that an error wins over completion.

// File: rtl/zeng_pkg.sv
package zeng_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CODE_W = 4;

  localparam logic [ADDR_W-1:0] A_SIZE_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_SIZE_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_THRESH  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd4;
  localparam logic [ADDR_W-1:0] A_ERR     = 4'd5;
  localparam logic [ADDR_W-1:0] A_OCNT_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_OCNT_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_CCNT_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_CCNT_HI = 4'd9;

  localparam logic [DATA_W-1:0] OP_COMP   = 8'h01;
  localparam logic [DATA_W-1:0] OP_DECOMP = 8'h02;

  localparam logic [DATA_W-1:0] ST_IDLE = 8'h00;
  localparam logic [DATA_W-1:0] ST_BUSY = 8'h80;
  localparam logic [DATA_W-1:0] ST_DONE = 8'h01;
  localparam logic [DATA_W-1:0] ST_FAIL = 8'h02;

  localparam int EB_CMD_BUSY = 0;
  localparam int EB_NO_SIZE  = 1;
  localparam int EC_LSB      = 4;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_DONE = 2'd1,
    OUT_FAIL = 2'd2
  } outcome_e;
endpackage

// File: rtl/zeng_cnt.sv
module zeng_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | inc;
    q_d  = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/zeng_regs.sv
module zeng_regs
  import zeng_pkg::*;
#(
  parameter int              CNT_W      = 16,
  parameter logic [DATA_W-1:0] THRESH_RST = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              launch,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] err,
  input  logic [CNT_W-1:0]  ocnt,
  input  logic [CNT_W-1:0]  ccnt,
  output logic [CNT_W-1:0]  size_q,
  output logic [DATA_W-1:0] thresh_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int WIDE = 2 * DATA_W;

  logic [WIDE-1:0]   size_w, size_wn, ocnt_w, ccnt_w;
  logic [CNT_W-1:0]  size_d;
  logic              size_en, thresh_en, cmd_en;

  always_comb begin
    size_w  = WIDE'(size_q);
    size_wn = size_w;
    if (addr == A_SIZE_HI) size_wn[WIDE-1:DATA_W] = wdata;
    else                   size_wn[DATA_W-1:0]    = wdata;
    size_d    = size_wn[CNT_W-1:0];
    size_en   = we && !busy && (addr == A_SIZE_LO || addr == A_SIZE_HI);
    thresh_en = we && (addr == A_THRESH);
    cmd_en    = launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      thresh_q <= THRESH_RST;
      cmd_q    <= '0;
    end else begin
      if (size_en)   size_q   <= size_d;
      if (thresh_en) thresh_q <= wdata;
      if (cmd_en)    cmd_q    <= wdata;
    end
  end

  always_comb begin
    ocnt_w = WIDE'(ocnt);
    ccnt_w = WIDE'(ccnt);
    unique case (addr)
      A_SIZE_LO: rdata = size_w[DATA_W-1:0];
      A_SIZE_HI: rdata = size_w[WIDE-1:DATA_W];
      A_THRESH:  rdata = thresh_q;
      A_CMD:     rdata = cmd_q;
      A_STAT:    rdata = stat;
      A_ERR:     rdata = err;
      A_OCNT_LO: rdata = ocnt_w[DATA_W-1:0];
      A_OCNT_HI: rdata = ocnt_w[WIDE-1:DATA_W];
      A_CCNT_LO: rdata = ccnt_w[DATA_W-1:0];
      A_CCNT_HI: rdata = ccnt_w[WIDE-1:DATA_W];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/zeng_seq.sv
module zeng_seq
  import zeng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              size_zero,
  input  logic              orig_tick,
  input  logic              orig_hit,
  input  logic              dp_err,
  input  logic [CODE_W-1:0] dp_err_code,
  output logic              launch,
  output logic              busy,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] err_q,
  output logic              irq_n,
  output logic              dp_start,
  output logic              dp_clear,
  output logic              dp_cancel,
  output logic              dp_mode
);
  outcome_e          outcome;
  logic              is_start;
  logic [DATA_W-1:0] stat_d, err_d, err_set;
  logic              irq_d, mode_d, start_d, cancel_d;

  assign busy = stat_q[7];

  always_comb begin
    is_start = cmd_wr && (wdata == OP_COMP || wdata == OP_DECOMP);
    launch   = is_start && !busy && !size_zero;

    if (busy && dp_err)                      outcome = OUT_FAIL;
    else if (busy && orig_tick && orig_hit)  outcome = OUT_DONE;
    else                                     outcome = OUT_NONE;

    err_set = '0;
    err_set[EB_CMD_BUSY] = is_start && busy;
    err_set[EB_NO_SIZE]  = is_start && !busy && size_zero;
    if (outcome == OUT_FAIL) err_set[DATA_W-1:EC_LSB] = dp_err_code;

    stat_d = stat_q;
    irq_d  = irq_n;
    err_d  = err_q | err_set;
    if (launch) begin
      stat_d = ST_BUSY;
      irq_d  = 1'b1;
      err_d  = '0;
    end else if (outcome == OUT_DONE) begin
      stat_d = ST_DONE;
      irq_d  = 1'b0;
    end else if (outcome == OUT_FAIL) begin
      stat_d = ST_FAIL;
      irq_d  = 1'b0;
    end

    start_d  = launch;
    cancel_d = (outcome == OUT_FAIL);
    mode_d   = launch ? (wdata == OP_DECOMP) : dp_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= ST_IDLE;
      err_q     <= '0;
      irq_n     <= 1'b1;
      dp_start  <= 1'b0;
      dp_clear  <= 1'b0;
      dp_cancel <= 1'b0;
      dp_mode   <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      err_q     <= err_d;
      irq_n     <= irq_d;
      dp_start  <= start_d;
      dp_clear  <= start_d;
      dp_cancel <= cancel_d;
      dp_mode   <= mode_d;
    end
  end
endmodule

// File: rtl/zeng_ctrl.sv
module zeng_ctrl
  import zeng_pkg::*;
#(
  parameter int        CNT_W      = 16,
  parameter logic [7:0] THRESH_RST = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_we,
  output logic [7:0] host_rdata,
  output logic [7:0] fifo_thresh,
  output logic       dp_mode,
  output logic       dp_start,
  output logic       dp_clear,
  output logic       dp_cancel,
  input  logic       dp_orig_tick,
  input  logic       dp_comp_tick,
  input  logic       dp_err,
  input  logic [3:0] dp_err_code,
  output logic       irq_n
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_i_n;
  logic              launch, busy, orig_hit, size_zero;
  logic [7:0]        stat_q, err_q, cmd_q;
  logic [CNT_W-1:0]  size_q, ocnt_q, ccnt_q;
  logic [CNT_W:0]    ocnt_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_N-1];

  always_comb begin
    ocnt_next = {1'b0, ocnt_q} + 1'b1;
    orig_hit  = (ocnt_next == {1'b0, size_q});
    size_zero = (size_q == '0);
  end

  zeng_regs #(.CNT_W(CNT_W), .THRESH_RST(THRESH_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (host_we),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .busy     (busy),
    .launch   (launch),
    .stat     (stat_q),
    .err      (err_q),
    .ocnt     (ocnt_q),
    .ccnt     (ccnt_q),
    .size_q   (size_q),
    .thresh_q (fifo_thresh),
    .cmd_q    (cmd_q),
    .rdata    (host_rdata)
  );

  zeng_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cmd_wr      (host_we && host_addr == A_CMD),
    .wdata       (host_wdata),
    .size_zero   (size_zero),
    .orig_tick   (dp_orig_tick),
    .orig_hit    (orig_hit),
    .dp_err      (dp_err),
    .dp_err_code (dp_err_code),
    .launch      (launch),
    .busy        (busy),
    .stat_q      (stat_q),
    .err_q       (err_q),
    .irq_n       (irq_n),
    .dp_start    (dp_start),
    .dp_clear    (dp_clear),
    .dp_cancel   (dp_cancel),
    .dp_mode     (dp_mode)
  );

  zeng_cnt #(.W(CNT_W)) u_ocnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (launch),
    .inc   (busy && dp_orig_tick),
    .q     (ocnt_q)
  );

  zeng_cnt #(.W(CNT_W)) u_ccnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (launch),
    .inc   (busy && dp_comp_tick),
    .q     (ccnt_q)
  );
endmodule

// File: rtl/zeng_ctrl_chk.sv
module zeng_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             dp_start,
  input logic             dp_clear,
  input logic             dp_cancel,
  input logic [7:0]       stat,
  input logic [7:0]       err,
  input logic [CNT_W-1:0] ocnt,
  input logic [CNT_W-1:0] ccnt,
  input logic [CNT_W-1:0] size
);
  p_launch_values_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |-> (stat == 8'h80 && err == 8'h00 && ocnt == '0 && ccnt == '0 && irq_n && dp_clear));

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> !dp_start);

  p_busy_below_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] |-> (ocnt < size));

  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stat[7]) && stat[0]) |-> !irq_n);

  p_cancel_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_cancel |-> (stat == 8'h02 && !irq_n));

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !stat[7]);

  p_size_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] && $past(stat[7])) |-> $stable(size));
endmodule

bind zeng_ctrl zeng_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .irq_n     (irq_n),
  .dp_start  (dp_start),
  .dp_clear  (dp_clear),
  .dp_cancel (dp_cancel),
  .stat      (stat_q),
  .err       (err_q),
  .ocnt      (ocnt_q),
  .ccnt      (ccnt_q),
  .size      (size_q)
);

// File: tb/zeng_ctrl_bench.sv
module zeng_ctrl_bench;
  localparam int         CNT_W = 12;
  localparam logic [7:0] TRST  = 8'h2A;
  localparam int         MASK  = (1 << CNT_W) - 1;

  logic       clk;
  logic       rst_n;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic       host_we;
  logic [7:0] host_rdata;
  logic [7:0] fifo_thresh;
  logic       dp_mode, dp_start, dp_clear, dp_cancel;
  logic       dp_orig_tick, dp_comp_tick, dp_err;
  logic [3:0] dp_err_code;
  logic       irq_n;

  int checks;
  int errors;
  bit done_flag;

  zeng_ctrl #(.CNT_W(CNT_W), .THRESH_RST(TRST)) u_zeng_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .fifo_thresh(fifo_thresh),
    .dp_mode(dp_mode), .dp_start(dp_start), .dp_clear(dp_clear), .dp_cancel(dp_cancel),
    .dp_orig_tick(dp_orig_tick), .dp_comp_tick(dp_comp_tick), .dp_err(dp_err),
    .dp_err_code(dp_err_code), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  int   m_size, m_thr, m_cmd, m_stat, m_err, m_oc, m_cc;
  bit   m_irqn, m_start, m_clear, m_cancel, m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_size = 0; m_thr = TRST; m_cmd = 0; m_stat = 0; m_err = 0; m_oc = 0; m_cc = 0;
      m_irqn = 1; m_start = 0; m_clear = 0; m_cancel = 0; m_mode = 0;
    end else begin
      bit busy, fail, fin;
      busy = (m_stat == 8'h80);
      m_start = 0; m_clear = 0; m_cancel = 0;
      fail = busy && dp_err;
      fin  = busy && !dp_err && dp_orig_tick && (m_oc + 1 == m_size);
      if (busy && dp_orig_tick) m_oc = (m_oc + 1) & MASK;
      if (busy && dp_comp_tick) m_cc = (m_cc + 1) & MASK;
      if (fail) begin
        m_err = m_err | (int'(dp_err_code) << 4);
        m_stat = 8'h02; m_irqn = 0; m_cancel = 1;
      end else if (fin) begin
        m_stat = 8'h01; m_irqn = 0;
      end
      if (host_we) begin
        case (host_addr)
          4'd0: if (!busy) m_size = ((m_size & 16'hFF00) | host_wdata) & MASK;
          4'd1: if (!busy) m_size = ((int'(host_wdata) << 8) | (m_size & 8'hFF)) & MASK;
          4'd2: m_thr = host_wdata;
          4'd3: if (host_wdata == 8'h01 || host_wdata == 8'h02) begin
                  if (busy) m_err = m_err | 1;
                  else if (m_size == 0) m_err = m_err | 2;
                  else begin
                    m_cmd = host_wdata; m_stat = 8'h80; m_err = 0; m_oc = 0; m_cc = 0;
                    m_irqn = 1; m_start = 1; m_clear = 1; m_mode = (host_wdata == 8'h02);
                  end
                end
          default: ;
        endcase
      end
    end
  end

  function automatic int m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_size & 8'hFF;
      4'd1: return m_size >> 8;
      4'd2: return m_thr;
      4'd3: return m_cmd;
      4'd4: return m_stat;
      4'd5: return m_err;
      4'd6: return m_oc & 8'hFF;
      4'd7: return m_oc >> 8;
      4'd8: return m_cc & 8'hFF;
      4'd9: return m_cc >> 8;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1: return "R9";
      4'd2: return "R10";
      4'd3: return "R11";
      4'd4: return "R6";
      4'd5: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(host_rdata, m_read(host_addr), tag_of(host_addr), "rdata vs model");
      check(irq_n, m_irqn, "R8", "irq_n vs model");
      check(dp_start, m_start, "R2", "dp_start vs model");
      check(dp_clear, m_clear, "R2", "dp_clear vs model");
      check(dp_cancel, m_cancel, "R7", "dp_cancel vs model");
      check(dp_mode, m_mode, "R2", "dp_mode vs model");
      check(fifo_thresh, m_thr, "R10", "fifo_thresh vs model");
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    step();
    host_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input int exp, input string tag);
    host_addr = a;
    @(negedge clk);
    check(host_rdata, exp, tag, "register read");
    step();
  endtask

  task automatic expect_pin(input int act, input int exp, input string tag, input string what);
    @(negedge clk);
    check(act, exp, tag, what);
    step();
  endtask

  task automatic ticks(input bit o, input bit c, input int n);
    dp_orig_tick = o; dp_comp_tick = c;
    repeat (n) step();
    dp_orig_tick = 0; dp_comp_tick = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; done_flag = 0;
    host_addr = 0; host_wdata = 0; host_we = 0;
    dp_orig_tick = 0; dp_comp_tick = 0; dp_err = 0; dp_err_code = 0;
    do_reset();

    // R1 reset state
    expect_rd(4'd4, 8'h00, "R1");
    expect_rd(4'd5, 8'h00, "R1");
    expect_rd(4'd2, TRST, "R1");
    expect_pin(irq_n, 1, "R1", "irq_n after reset");

    // R10 threshold
    wr(4'd2, 8'h55);
    expect_pin(fifo_thresh, 8'h55, "R10", "fifo_thresh");

    // R3 start with zero size
    wr(4'd3, 8'h01);
    expect_rd(4'd5, 8'h02, "R3");
    expect_rd(4'd4, 8'h00, "R3");

    // R9 high bits masked
    wr(4'd1, 8'hFF);
    expect_rd(4'd1, 8'h0F, "R9");
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h05);

    // R11 non-start opcode ignored
    wr(4'd3, 8'h07);
    expect_rd(4'd3, 8'h00, "R11");

    // R5 idle ticks ignored
    ticks(1, 1, 2);
    expect_rd(4'd6, 8'h00, "R5");

    // R2 launch compress
    wr(4'd3, 8'h01);
    expect_pin(dp_start, 1, "R2", "dp_start pulse");
    expect_pin(dp_start, 0, "R2", "dp_start one cycle");
    expect_rd(4'd4, 8'h80, "R2");
    expect_rd(4'd5, 8'h00, "R2");
    expect_rd(4'd3, 8'h01, "R11");

    ticks(1, 1, 2);
    ticks(1, 0, 1);
    expect_rd(4'd6, 8'h03, "R5");
    expect_rd(4'd8, 8'h02, "R5");

    // R9 size write while busy, R12 read-only writes
    wr(4'd0, 8'h09);
    expect_rd(4'd0, 8'h05, "R9");
    wr(4'd4, 8'hFF);
    wr(4'd5, 8'hFF);
    wr(4'd6, 8'hFF);
    expect_rd(4'd4, 8'h80, "R12");
    expect_rd(4'd5, 8'h00, "R12");
    expect_rd(4'd6, 8'h03, "R12");

    // R4 start while busy
    wr(4'd3, 8'h02);
    expect_rd(4'd5, 8'h01, "R4");
    expect_rd(4'd6, 8'h03, "R4");
    expect_pin(dp_mode, 0, "R4", "dp_mode kept");

    // R6 completion
    ticks(1, 0, 2);
    expect_rd(4'd4, 8'h01, "R6");
    expect_pin(irq_n, 0, "R6", "irq_n on done");
    expect_rd(4'd6, 8'h05, "R6");
    ticks(1, 1, 3);
    expect_rd(4'd6, 8'h05, "R5");
    expect_pin(irq_n, 0, "R8", "irq_n held low");

    // R8 relaunch decompress with size 300
    wr(4'd0, 8'h2C);
    wr(4'd1, 8'h01);
    wr(4'd3, 8'h02);
    expect_pin(irq_n, 1, "R8", "irq_n on relaunch");
    expect_pin(dp_mode, 1, "R2", "dp_mode decompress");
    ticks(1, 1, 299);
    expect_rd(4'd7, 8'h01, "R5");

    // R7 error together with final tick
    dp_orig_tick = 1; dp_err = 1; dp_err_code = 4'h5;
    step();
    dp_orig_tick = 0; dp_err = 0; dp_err_code = 0;
    @(negedge clk);
    check(dp_cancel, 1, "R7", "dp_cancel pulse");
    step();
    expect_rd(4'd4, 8'h02, "R7");
    expect_rd(4'd5, 8'h50, "R7");
    expect_rd(4'd6, 8'h2C, "R7");
    expect_rd(4'd7, 8'h01, "R7");
    expect_rd(4'd8, 8'h2B, "R5");
    expect_pin(irq_n, 0, "R7", "irq_n on error");

    // full run of 300 bytes
    wr(4'd3, 8'h01);
    expect_rd(4'd5, 8'h00, "R2");
    ticks(1, 0, 300);
    expect_rd(4'd4, 8'h01, "R6");
    expect_rd(4'd7, 8'h01, "R6");

    // reset in the middle of a job
    wr(4'd3, 8'h01);
    ticks(1, 1, 4);
    do_reset();
    expect_rd(4'd4, 8'h00, "R1");
    expect_rd(4'd6, 8'h00, "R1");
    expect_rd(4'd0, 8'h00, "R1");
    expect_pin(fifo_thresh, TRST, "R1", "fifo_thresh after reset");
    expect_pin(irq_n, 1, "R1", "irq_n after reset");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule